// File: doc/BRIEF.md
# Baud-Rate Divider with Asynchronous Serial Transmitter

This block takes the system clock and a 16-bit divisor and makes a one-cycle enable pulse at sixteen times the baud rate. It drives the same pulse train out, active low, so that other logic can reuse the oversampled rate. The pulses time a serial transmitter. Software writes a character into a holding register. The transmitter moves the character into its shifter and sends a frame on the serial line. The frame is a low start bit, then 5 to 8 data bits with the least significant bit first, then an optional parity bit, then a high stop period.

The frame shape comes from a small line-control register. One field sets the character length. One bit enables parity and another picks even or odd parity. One bit lengthens the stop period. That bit gives one and a half bit times for 5-bit characters and two bit times for the other lengths. Each bit cell lasts 16 enable pulses. Two status outputs show whether the holding register and the shifter are empty. A character that waits in the holding register starts as soon as the frame before it ends, with no idle cycle between frames.

Top module: `baud_tx_unit`

## Requirements
- R1: While reset is asserted and just after it is released: `sout` = 1, `baudout_n` = 1, `thr_empty` = 1, `tsr_empty` = 1, and the line-control register reads as 0 (5 data bits, no parity, short stop).
- R2: With divisor N ≥ 1 the generator gives exactly one enable pulse every N clocks. `baudout_n` is low for one clock after each pulse, so with N = 1 it stays low.
- R3: A divisor of 0 stops the generator. No pulses are produced and `baudout_n` stays high.
- R4: Reset does not clear the divisor bytes. After reset the generator keeps the rate that was programmed before it.
- R5: A write with `wr_en` = 1 is decoded by `wr_sel`: 0 = holding register, 1 = divisor low byte, 2 = divisor high byte, 3 = line control (bits [4:0] used).
- R6: A frame is a start bit of 0, then the data bits LSB first, then the optional parity bit, then stop at 1. Each bit lasts 16 enable pulses, and `sout` is 1 whenever no frame is in progress.
- R7: Line control bits [1:0] set the character length: 00 = 5, 01 = 6, 10 = 7, 11 = 8 data bits. Holding-register bits above the length are not sent.
- R8: Line control bit 3 enables parity. Bit 4 = 1 selects even parity (the data bits plus the parity bit hold an even number of ones), and bit 4 = 0 selects odd parity.
- R9: The stop period is 16 pulses when line control bit 2 is 0. When bit 2 is 1 it is 24 pulses for 5-bit characters and 32 pulses for 6, 7 or 8 bits.
- R10: `thr_empty` goes low the clock after a holding-register write and goes high when the character moves into the shifter. `tsr_empty` is low exactly while a frame is on the line. A waiting character starts on the clock where the previous frame ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, divided by the generator |
| rst_n | input | 1 | Active-low master reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select for the write |
| wr_data | input | 8 | Write data |
| sout | output | 1 | Serial transmit line, idles high |
| baudout_n | output | 1 | Active-low 16x rate pulse |
| thr_empty | output | 1 | Holding register has no pending character |
| tsr_empty | output | 1 | Shifter idle, no frame in progress |

## Verification
The assertions assume that `wr_sel` and `wr_data` are valid whenever `wr_en` is high. They also assume that the divisor and line control stay fixed while a frame is being sent, because line control is captured only when a frame loads. The bench changes divisor and line control only while the shifter is idle. It writes the holding register at most once per frame, so no character is overwritten before it is sent. Most frame checks run with divisor 1, so every clock is a pulse and bit boundaries fall on exact clocks. One frame is sent at divisor 3, where the first bit can be up to two clocks short, and it is sampled at bit centres.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

  localparam int DIV_W      = 16;
  localparam int CHAR_W     = 8;
  localparam int TICKS_BIT  = 16;
  localparam int FRAME_MAX  = 1 + CHAR_W + 1 + 2;   // start + data + parity + stop slots
  localparam int TICK_CNT_W = 8;                    // holds 16*10 + 32 = 192

  localparam logic [1:0] SEL_HOLD   = 2'd0;
  localparam logic [1:0] SEL_DIV_LO = 2'd1;
  localparam logic [1:0] SEL_DIV_HI = 2'd2;
  localparam logic [1:0] SEL_LINE   = 2'd3;

  typedef struct packed {
    logic       even;       // [4]
    logic       par_en;     // [3]
    logic       long_stop;  // [2]
    logic [1:0] wlen;       // [1:0]
  } line_ctl_t;

  // data bits per character
  function automatic logic [3:0] char_bits(line_ctl_t lc);
    return 4'd5 + {2'b00, lc.wlen};
  endfunction

  // stop period measured in 16x pulses
  function automatic int unsigned stop_ticks(line_ctl_t lc);
    if (!lc.long_stop)        return 16;
    else if (lc.wlen == 2'b00) return 24;
    else                      return 32;
  endfunction

  // total pulses in one frame
  function automatic logic [TICK_CNT_W-1:0] frame_ticks(line_ctl_t lc);
    int unsigned slots;
    slots = 1 + int'(char_bits(lc)) + (lc.par_en ? 1 : 0);
    return TICK_CNT_W'(slots * TICKS_BIT + stop_ticks(lc));
  endfunction

  // serial word, bit 0 leaves first; stop and fill bits are 1
  function automatic logic [FRAME_MAX-1:0] frame_word(logic [CHAR_W-1:0] d, line_ctl_t lc);
    logic [FRAME_MAX-1:0] fw;
    logic [3:0]           n;
    logic                 ones;
    n    = char_bits(lc);
    fw   = '1;
    fw[0] = 1'b0;
    ones = 1'b0;
    for (int i = 0; i < CHAR_W; i++) begin
      if (i < int'(n)) begin
        fw[i+1] = d[i];
        ones    = ones ^ d[i];
      end
    end
    if (lc.par_en) fw[n+1] = lc.even ? ones : ~ones;
    return fw;
  endfunction

endpackage

// File: rtl/baud_gen.sv
module baud_gen
  import uart_tx_pkg::*;
#(
  parameter int W = DIV_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] divisor,
  output logic         tick,
  output logic         baudout_n
);
  logic [W-1:0] cnt;
  logic         run;

  assign run  = (divisor != '0);
  assign tick = run && (cnt >= divisor - W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt       <= '0;
      baudout_n <= 1'b1;
    end else begin
      cnt       <= (!run || tick) ? '0 : cnt + W'(1);
      baudout_n <= ~tick;
    end
  end
endmodule

// File: rtl/tx_hold.sv
module tx_hold
  import uart_tx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [CHAR_W-1:0] wdata,
  input  logic              take,
  output logic [CHAR_W-1:0] hold_q,
  output logic              full
);
  // contents survive reset, only the flag is cleared
  always_ff @(posedge clk) begin
    if (wr) hold_q <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    full <= 1'b0;
    else if (wr)   full <= 1'b1;
    else if (take) full <= 1'b0;
  end
endmodule

// File: rtl/tx_shifter.sv
module tx_shifter
  import uart_tx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              load,
  input  logic [CHAR_W-1:0] data,
  input  line_ctl_t         lc,
  output logic              active,
  output logic              finishing,
  output logic              sout
);
  logic [FRAME_MAX-1:0]  shreg;
  logic [3:0]            phase;
  logic [TICK_CNT_W-1:0] left;

  assign finishing = active && tick && (left == TICK_CNT_W'(1));
  assign sout      = active ? shreg[0] : 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      shreg  <= '1;
      phase  <= '0;
      left   <= '0;
    end else if (load) begin
      active <= 1'b1;
      shreg  <= frame_word(data, lc);
      phase  <= '0;
      left   <= frame_ticks(lc);
    end else if (active && tick) begin
      phase <= phase + 4'd1;
      if (phase == 4'(TICKS_BIT - 1)) shreg <= {1'b1, shreg[FRAME_MAX-1:1]};
      if (finishing) active <= 1'b0;
      else           left   <= left - TICK_CNT_W'(1);
    end
  end
endmodule

// File: rtl/baud_tx_unit.sv
module baud_tx_unit
  import uart_tx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [1:0] wr_sel,
  input  logic [7:0] wr_data,
  output logic       sout,
  output logic       baudout_n,
  output logic       thr_empty,
  output logic       tsr_empty
);
  logic [DIV_W-1:0]  div_q;
  line_ctl_t         line_q;
  logic              baud_tick;
  logic              load_evt;
  logic              hold_full;
  logic [CHAR_W-1:0] hold_q;
  logic              tx_active;
  logic              tx_finishing;

  // divisor bytes are not reset
  always_ff @(posedge clk) begin
    if (wr_en && wr_sel == SEL_DIV_LO) div_q[7:0]       <= wr_data;
    if (wr_en && wr_sel == SEL_DIV_HI) div_q[DIV_W-1:8] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                           line_q <= '0;
    else if (wr_en && wr_sel == SEL_LINE) line_q <= line_ctl_t'(wr_data[4:0]);
  end

  assign load_evt  = hold_full && (!tx_active || tx_finishing);
  assign thr_empty = ~hold_full;
  assign tsr_empty = ~tx_active;

  baud_gen #(.W(DIV_W)) u_gen (
    .clk       (clk),
    .rst_n     (rst_n),
    .divisor   (div_q),
    .tick      (baud_tick),
    .baudout_n (baudout_n)
  );

  tx_hold u_hold (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr     (wr_en && wr_sel == SEL_HOLD),
    .wdata  (wr_data),
    .take   (load_evt),
    .hold_q (hold_q),
    .full   (hold_full)
  );

  tx_shifter u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (baud_tick),
    .load      (load_evt),
    .data      (hold_q),
    .lc        (line_q),
    .active    (tx_active),
    .finishing (tx_finishing),
    .sout      (sout)
  );
endmodule

// File: rtl/baud_tx_unit_chk.sv
module baud_tx_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] divisor,
  input logic        baud_tick,
  input logic        load_evt,
  input logic        wr_en,
  input logic [1:0]  wr_sel,
  input logic        sout,
  input logic        baudout_n,
  input logic        thr_empty,
  input logic        tsr_empty
);
  // R3
  zero_div_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (divisor == 16'd0) |=> baudout_n);

  // R2
  div_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(divisor) == 16'd1) |-> !baudout_n);

  // R10
  thr_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == 2'd0) |=> !thr_empty);

  // R6
  start_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |=> (!sout && !tsr_empty));

  // R6
  idle_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tsr_empty |-> sout);

  // R6
  bit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(baud_tick) && !$past(load_evt)) |-> $stable(sout));
endmodule

bind baud_tx_unit baud_tx_unit_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .divisor   (div_q),
  .baud_tick (baud_tick),
  .load_evt  (load_evt),
  .wr_en     (wr_en),
  .wr_sel    (wr_sel),
  .sout      (sout),
  .baudout_n (baudout_n),
  .thr_empty (thr_empty),
  .tsr_empty (tsr_empty)
);

// File: tb/baud_tx_unit_bench.sv
module baud_tx_unit_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_sel = 2'd0;
  logic [7:0] wr_data = 8'd0;
  logic       sout, baudout_n, thr_empty, tsr_empty;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #10 clk = ~clk;   // 50 MHz

  baud_tx_unit u_baud_tx_unit (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .sout(sout), .baudout_n(baudout_n), .thr_empty(thr_empty), .tsr_empty(tsr_empty)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic set_div(input int dv);
    wr(2'd1, 8'(dv));
    wr(2'd2, 8'(dv >> 8));
  endtask

  task automatic pulse_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic count_low(input int win, output int n);
    n = 0;
    for (int i = 0; i < win; i++) begin
      @(negedge clk);
      if (!baudout_n) n++;
    end
  endtask

  // expected serial bits, independent of the design
  function automatic int exp_bit(input logic [7:0] d, input logic [4:0] lc, input int k);
    int n, p, ones;
    n = 5 + int'(lc[1:0]);
    p = lc[3] ? 1 : 0;
    ones = 0;
    for (int i = 0; i < n; i++) ones += d[i];
    if (k == 0) return 0;
    if (k <= n) return int'(d[k-1]);
    if (p == 1 && k == n + 1) return lc[4] ? (ones % 2) : 1 - (ones % 2);
    return 1;
  endfunction

  function automatic int exp_len(input logic [4:0] lc);
    int n, p, st;
    n = 5 + int'(lc[1:0]);
    p = lc[3] ? 1 : 0;
    st = !lc[2] ? 16 : (n == 5 ? 24 : 32);
    return 16 * (1 + n + p) + st;
  endfunction

  // sample one frame at bit centres; optionally measure its length (divisor 1)
  task automatic send_check(input logic [7:0] d, input logic [4:0] lc, input int cpb,
                            input bit chk_len, input string tag);
    int rel, t, slots;
    wr(2'd3, {3'b000, lc});
    wr(2'd0, d);
    t = 0;
    while (sout !== 1'b0 && t < 5000) begin @(negedge clk); t++; end
    check({tag, " start seen"}, int'(t < 5000), 1);
    rel = 0;
    slots = 1 + 5 + int'(lc[1:0]) + (lc[3] ? 1 : 0) + 1;
    for (int k = 0; k < slots; k++) begin
      while (rel < cpb / 2 + cpb * k) begin @(negedge clk); rel++; end
      check($sformatf("%s bit %0d", tag, k), int'(sout), exp_bit(d, lc, k));
    end
    if (chk_len) begin
      while (tsr_empty == 1'b0 && rel < 1000) begin @(negedge clk); rel++; end
      check({tag, " frame length"}, rel, exp_len(lc));
    end else begin
      t = 0;
      while (tsr_empty == 1'b0 && t < 5000) begin @(negedge clk); t++; end
    end
  endtask

  task automatic t_reset();
    check("R1 sout", int'(sout), 1);
    check("R1 baudout_n", int'(baudout_n), 1);
    check("R1 thr_empty", int'(thr_empty), 1);
    check("R1 tsr_empty", int'(tsr_empty), 1);
  endtask

  task automatic t_divider();
    int n;
    set_div(5);
    repeat (10) @(negedge clk);
    count_low(100, n);
    check("R2 R5 pulses at div 5", n, 20);
    set_div(1);
    repeat (3) @(negedge clk);
    count_low(50, n);
    check("R2 pulses at div 1", n, 50);
    set_div(0);
    repeat (3) @(negedge clk);
    count_low(100, n);
    check("R3 no pulses at div 0", n, 0);
  endtask

  task automatic t_div_retain();
    int n;
    set_div(5);
    pulse_reset();
    repeat (10) @(negedge clk);
    count_low(100, n);
    check("R4 divisor kept over reset", n, 20);
  endtask

  task automatic t_frames();
    set_div(1);
    pulse_reset();
    send_check(8'hD5, 5'b00000, 16, 1'b1, "R1 R7 line ctl reset 5N1");
    send_check(8'hA5, 5'b00011, 16, 1'b1, "R6 8N1");
    send_check(8'h2E, 5'b00001, 16, 1'b1, "R7 6N1");
    send_check(8'h34, 5'b11010, 16, 1'b1, "R8 7 even");
    send_check(8'h34, 5'b01010, 16, 1'b1, "R8 7 odd");
    send_check(8'h9B, 5'b11011, 16, 1'b1, "R8 8 even");
    send_check(8'h13, 5'b00100, 16, 1'b1, "R9 5 bit 1.5 stop");
    send_check(8'hC3, 5'b00111, 16, 1'b1, "R9 8 bit 2 stop");
    send_check(8'h2A, 5'b01101, 16, 1'b1, "R9 6 bit parity 2 stop");
    set_div(3);
    send_check(8'h6C, 5'b00011, 48, 1'b0, "R2 R6 div 3 frame");
    set_div(1);
  endtask

  task automatic t_back_to_back();
    wr(2'd3, 8'h03);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = 2'd0; wr_data = 8'hFF;
    @(negedge clk);
    wr_data = 8'h00;
    @(negedge clk);
    wr_en = 1'b0;
    // rel 0: first frame started, second character waiting
    check("R10 first frame running", int'(sout), 0);
    check("R10 holding full while busy", int'(thr_empty), 0);
    check("R10 shifter busy", int'(tsr_empty), 0);
    for (int rel = 1; rel <= 160; rel++) begin
      @(negedge clk);
      if (rel == 159) check("R10 stop before next start", int'(sout), 1);
      if (rel == 160) begin
        check("R10 next start no gap", int'(sout), 0);
        check("R10 holding emptied on load", int'(thr_empty), 1);
        check("R10 shifter stays busy", int'(tsr_empty), 0);
      end
    end
    for (int rel = 161; rel <= 320; rel++) @(negedge clk);
    check("R10 shifter idle after frames", int'(tsr_empty), 1);
    check("R6 line idles high", int'(sout), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_divider();
    t_div_retain();
    t_frames();
    t_back_to_back();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule